// File: doc/BRIEF.md
# Nearest-Neighbour Hit Expansion

This block sits in the digital control of a multi-channel pixel detector readout. A 10x10 pixel array is served by 100 readout channels. When a charge deposit is shared between adjacent pixels, reading out only the channels above threshold loses part of the energy. The block therefore widens every accepted hit to the up to eight pixels that surround it, including the diagonal ones. It then produces a per-channel read request for the sampling logic that follows.

Channel numbers do not follow the pixel geometry, so adjacency is resolved in pixel space. Each channel is mapped to a pixel by a fixed table: pixel = (channel * STRIDE) mod 100, with row = pixel / 10 and column = pixel mod 10. STRIDE is a parameter that is coprime with the channel count. The surrounding pixels are found there and mapped back to channels. A per-channel mask removes dead or noisy channels completely. A second output vector marks which requests are true hits and which are only neighbours. Both vectors are registered and are updated only on cycles where the hit vector is strobed in.

Top module: `nn_hit_expand`

## Requirements
- R1: After reset, `rd_req` and `hit_flag` are all zero.
- R2: After a strobed sample, `hit_flag[c]` is 1 exactly when `hits[c]` was 1 and `chan_mask[c]` was 0.
- R3: Every channel with an unmasked hit is requested in `rd_req`.
- R4: An unmasked channel is requested when its pixel is one of the eight surrounding pixels (row and column each differing by at most 1, diagonals included) of a pixel whose channel has an unmasked hit, using pixel = (channel*STRIDE) mod 100, row = pixel/10, column = pixel mod 10, and the default STRIDE of 37.
- R5: With no mask and a single hit, the number of requests is 4 for a corner pixel, 6 for an edge pixel and 9 for an interior pixel.
- R6: A channel whose `chan_mask` bit is 1 is never requested or flagged, and a hit on it causes no neighbour requests.
- R7: A channel that is hit and is also a neighbour of another hit keeps `hit_flag` at 1.
- R8: Outputs change on the rising edge where `hit_strobe` is 1, reflecting the inputs sampled at that edge, and hold their value on edges where `hit_strobe` is 0.
- R9: No channel is requested other than those that R3 and R4 require.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hit_strobe | input | 1 | Samples `hits` and `chan_mask` on this edge |
| hits | input | 100 | Above-threshold flags, indexed by channel |
| chan_mask | input | 100 | 1 disables the channel |
| rd_req | output | 100 | Registered read request per channel |
| hit_flag | output | 100 | Registered: 1 for a direct hit, 0 for a neighbour-only request |

## Verification
A wrong entry in the channel-to-pixel table, or a wrong boundary test, shows up at the ports. It appears one cycle after the strobe as a missing or extra request next to a hit on the affected pixel. Corner, edge and interior hits catch the boundary errors. Random sparse patterns reach the rest of the table. A mask or flag fault appears in the same cycle as a wrong bit in `rd_req` or `hit_flag`. A broken clock enable appears as outputs that move on a cycle with no strobe.

// File: rtl/nn_hit_pkg.sv
package nn_hit_pkg;

  // Pixel position of a channel in the scrambled layout.
  function automatic int pix_of_chan(int ch, int stride, int nch);
    return (ch * stride) % nch;
  endfunction

  // Inverse of pix_of_chan (valid when stride is coprime with nch).
  function automatic int chan_of_pix(int pix, int stride, int nch);
    for (int c = 0; c < nch; c++) begin
      if ((c * stride) % nch == pix) return c;
    end
    return 0;
  endfunction

endpackage

// File: rtl/nn_rst_sync.sv
module nn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/nn_nbr_gather.sv
// For every channel, OR together the hit bits of the channels whose
// pixels surround its own pixel. Wiring is fixed at elaboration.
module nn_nbr_gather #(
  parameter int ROWS   = 10,
  parameter int COLS   = 10,
  parameter int STRIDE = 37,
  localparam int NCH   = ROWS * COLS
) (
  input  logic [NCH-1:0] hit_eff,
  output logic [NCH-1:0] nbr_hit
);
  import nn_hit_pkg::*;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int PIX = pix_of_chan(ch, STRIDE, NCH);
    localparam int PR  = PIX / COLS;
    localparam int PC  = PIX % COLS;
    logic [8:0] terms;

    for (genvar k = 0; k < 9; k++) begin : g_k
      localparam int NR = PR + (k / 3) - 1;
      localparam int NC = PC + (k % 3) - 1;
      if (k != 4 && NR >= 0 && NR < ROWS && NC >= 0 && NC < COLS) begin : g_in
        localparam int NB = chan_of_pix(NR * COLS + NC, STRIDE, NCH);
        assign terms[k] = hit_eff[NB];
      end else begin : g_out
        assign terms[k] = 1'b0;
      end
    end

    assign nbr_hit[ch] = |terms;
  end
endmodule

// File: rtl/nn_out_reg.sv
module nn_out_reg #(
  parameter int W = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/nn_hit_expand.sv
module nn_hit_expand #(
  parameter int ROWS   = 10,
  parameter int COLS   = 10,
  parameter int STRIDE = 37,
  localparam int NCH   = ROWS * COLS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit_strobe,
  input  logic [NCH-1:0] hits,
  input  logic [NCH-1:0] chan_mask,
  output logic [NCH-1:0] rd_req,
  output logic [NCH-1:0] hit_flag
);
  logic           rst_sync_n;
  logic [NCH-1:0] hit_eff;
  logic [NCH-1:0] nbr_hit;
  logic [NCH-1:0] req_d;
  logic [NCH-1:0] flag_d;

  nn_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb hit_eff = hits & ~chan_mask;

  nn_nbr_gather #(.ROWS(ROWS), .COLS(COLS), .STRIDE(STRIDE)) u_gather (
    .hit_eff (hit_eff),
    .nbr_hit (nbr_hit)
  );

  always_comb begin
    flag_d = hit_eff;
    req_d  = ~chan_mask & (hit_eff | nbr_hit);
  end

  nn_out_reg #(.W(NCH)) u_req_reg (
    .clk (clk), .rst_n (rst_sync_n), .en (hit_strobe), .d (req_d), .q (rd_req)
  );

  nn_out_reg #(.W(NCH)) u_flag_reg (
    .clk (clk), .rst_n (rst_sync_n), .en (hit_strobe), .d (flag_d), .q (hit_flag)
  );

  // R6: masked channels are never requested
  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit_strobe |=> (rd_req & $past(chan_mask)) == '0);

  // R3: every flagged hit is also requested
  a_r3_flag_in_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit_flag & ~rd_req) == '0);

  // R2: flag follows the strobed, unmasked hits
  a_r2_flag_sample: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit_strobe |=> hit_flag == ($past(hits) & ~$past(chan_mask)));

  // R8: outputs hold without a strobe
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit_strobe |=> ($stable(rd_req) && $stable(hit_flag)));

  // R9: at most nine requests per direct hit
  a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(rd_req) <= 9 * $countones(hit_flag));
endmodule

// File: tb/nn_hit_expand_tb.sv
module nn_hit_expand_tb;
  localparam int ROWS = 10, COLS = 10, N = 100, STRIDE = 37;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         hit_strobe;
  logic [N-1:0] hits, chan_mask, rd_req, hit_flag;
  int           n_run = 0, n_fail = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  nn_hit_expand #(.ROWS(ROWS), .COLS(COLS), .STRIDE(STRIDE)) u_dut (
    .clk, .rst_n, .hit_strobe, .hits, .chan_mask, .rd_req, .hit_flag
  );

  function automatic int pix(int c);
    return (c * STRIDE) % N;
  endfunction

  function automatic int chan_at(int p);
    for (int c = 0; c < N; c++) if (pix(c) == p) return c;
    return 0;
  endfunction

  function automatic bit adjacent(int a, int b);
    int dr, dc;
    dr = pix(a) / COLS - pix(b) / COLS;
    dc = pix(a) % COLS - pix(b) % COLS;
    return a != b && dr >= -1 && dr <= 1 && dc >= -1 && dc <= 1;
  endfunction

  function automatic logic [N-1:0] exp_req(logic [N-1:0] h, logic [N-1:0] m);
    logic [N-1:0] r = '0;
    for (int c = 0; c < N; c++) begin
      if (!m[c]) begin
        if (h[c]) r[c] = 1'b1;
        else for (int d = 0; d < N; d++)
          if (h[d] && !m[d] && adjacent(c, d)) r[c] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(logic [N-1:0] h, logic [N-1:0] m);
    @(negedge clk);
    hits = h; chan_mask = m; hit_strobe = 1'b1;
    @(negedge clk);
    hit_strobe = 1'b0;
  endtask

  task automatic full_check(string tag, logic [N-1:0] h, logic [N-1:0] m);
    logic [N-1:0] er, eff;
    apply(h, m);
    er  = exp_req(h, m);
    eff = h & ~m;
    chk({tag, " R2 flag"}, hit_flag, eff);
    chk({tag, " R4 req"}, rd_req, er);
    chk({tag, " R3 hits requested"}, eff & ~rd_req, '0);
    chk({tag, " R9 no extra"}, rd_req & ~er, '0);
    chk({tag, " R6 masked"}, (rd_req | hit_flag) & m, '0);
  endtask

  function automatic logic [N-1:0] one_hot(int c);
    logic [N-1:0] v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] h, m, prev_req, prev_flag;
    int c0, c1;
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; hit_strobe = 1'b0; hits = '0; chan_mask = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset req", rd_req, '0);
    chk("R1 reset flag", hit_flag, '0);

    // R5: corner, edge, interior single hits
    apply(one_hot(chan_at(0)), '0);
    chk_int("R5 corner count", $countones(rd_req), 4);
    apply(one_hot(chan_at(5)), '0);
    chk_int("R5 edge count", $countones(rd_req), 6);
    apply(one_hot(chan_at(55)), '0);
    chk_int("R5 interior count", $countones(rd_req), 9);
    full_check("interior", one_hot(chan_at(55)), '0);
    full_check("corner", one_hot(chan_at(99)), '0);

    // R6: masked hit makes no neighbours; masked neighbour dropped
    full_check("R6 masked hit", one_hot(chan_at(44)), one_hot(chan_at(44)));
    chk_int("R6 masked hit count", $countones(rd_req), 0);
    full_check("R6 masked nbr", one_hot(chan_at(44)), one_hot(chan_at(45)));
    chk_int("R6 masked nbr count", $countones(rd_req), 8);

    // R7: two adjacent hits both keep flag 1
    c0 = chan_at(33); c1 = chan_at(34);
    full_check("R7 adjacent", one_hot(c0) | one_hot(c1), '0);
    chk_int("R7 flags", {31'd0, hit_flag[c0]} + {31'd0, hit_flag[c1]}, 2);

    // all hit, and all masked
    full_check("all hit", '1, '0);
    full_check("all masked", '1, '1);

    // R8: no strobe -> hold
    full_check("R8 base", one_hot(chan_at(12)), '0);
    prev_req = rd_req; prev_flag = hit_flag;
    @(negedge clk);
    hits = one_hot(chan_at(77)); chan_mask = '0; hit_strobe = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 hold req", rd_req, prev_req);
    chk("R8 hold flag", hit_flag, prev_flag);

    // random sparse patterns
    for (int it = 0; it < 150; it++) begin
      for (int c = 0; c < N; c++) begin
        h[c] = ($urandom_range(0, 99) < 6);
        m[c] = ($urandom_range(0, 99) < 10);
      end
      full_check("rand", h, m);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule